// File: doc/BRIEF.md
# Pending Memory Access Tracker

This block watches a request/grant/response memory handshake and keeps a count of accesses that have been accepted but not yet answered. Both the acceptance of a new access and the completion of an older one can happen in the same clock cycle. The count is registered and driven out every cycle. An idle flag shows when nothing is in flight, so neighbouring logic can tell when the interface is quiet.

A response can carry a spurious marker. Such a response is not tied to any request. It is skipped by the counter and by the checks. The block also checks the protocol and reports two kinds of violation. The first is a real response that arrives while nothing is pending. The second is an acceptance that would take the count past a configured ceiling. Each violation is reported as a one-cycle pulse, one cycle after the offending handshake. Both checks can be masked by a single enable input. Masking is needed while responses are injected on purpose and break the normal rules.

Top module: `pending_access_tracker`

## Requirements
- R1: An access is accepted only in a cycle where `req_i` and `gnt_i` are both high; request alone or grant alone leaves `pending_o` unchanged.
- R2: Each accepted access, with no real response in the same cycle and the count below `MAX_OUTSTANDING`, raises `pending_o` by one on the next cycle.
- R3: A response (`rvalid_i` high) with `rspur_i` low lowers a non-zero `pending_o` by one on the next cycle. A response with `rspur_i` high changes neither the count nor any error output.
- R4: An acceptance and a real response in the same cycle, with a non-zero count, leave `pending_o` unchanged.
- R5: `idle_o` is high exactly when `pending_o` is zero.
- R6: A real response while `pending_o` is zero does not decrement; the count stays at zero, or becomes one if an access is accepted in the same cycle. When `chk_en_i` is high, `err_orphan_o` is high on the next cycle.
- R7: An acceptance without a real response while `pending_o` equals `MAX_OUTSTANDING` leaves the count at `MAX_OUTSTANDING`. When `chk_en_i` is high, `err_overlimit_o` is high on the next cycle.
- R8: With `chk_en_i` low, neither error output is raised, and counting behaves as in R1 to R7.
- R9: While `rst_i` is high at a clock edge, the count, `err_orphan_o` and `err_overlimit_o` are cleared, and `idle_o` goes high.
- R10: Each error output is high only in the cycle that follows an offending cycle, and it returns low after a cycle with no violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request from the requester |
| gnt_i | input | 1 | Grant from the memory side |
| rvalid_i | input | 1 | Response valid |
| rspur_i | input | 1 | Marks the current response as spurious |
| chk_en_i | input | 1 | Enables both protocol checks |
| pending_o | output | $clog2(MAX_OUTSTANDING+1) | Accepted accesses still awaiting a response |
| idle_o | output | 1 | High when no access is pending |
| err_orphan_o | output | 1 | Pulse: real response with nothing pending |
| err_overlimit_o | output | 1 | Pulse: acceptance beyond the ceiling |

## Verification
Acceptance and completion can fall in the same cycle. The bench provokes this in three places: mid-range, at the ceiling, where it must not be flagged as over-limit, and at zero, where the response is an orphan but the acceptance still counts. A behavioural integer model is updated on every edge. After each edge, at the falling edge, it is compared with the count, the idle flag and both error pulses. A pseudo-random stretch then mixes all four handshake inputs and toggles the check enable, so that the coincident cases also appear in orders that were not hand-picked.

// File: rtl/pat_pkg.sv
package pat_pkg;

    localparam int unsigned ERR_ORPHAN = 0;
    localparam int unsigned ERR_OVER   = 1;
    localparam int unsigned NUM_ERR    = 2;

    typedef struct packed {
        logic accept;
        logic retire;
    } hs_evt_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INC  = 2'd1,
        ACT_DEC  = 2'd2
    } cnt_act_e;

    function automatic cnt_act_e pick_action(input logic do_inc, input logic do_dec);
        if (do_inc && !do_dec) return ACT_INC;
        if (do_dec && !do_inc) return ACT_DEC;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/pat_hs_decode.sv
module pat_hs_decode
    import pat_pkg::*;
(
    input  logic    req_i,
    input  logic    gnt_i,
    input  logic    rvalid_i,
    input  logic    rspur_i,
    output hs_evt_t evt_o
);
    always_comb begin
        evt_o.accept = req_i & gnt_i;
        evt_o.retire = rvalid_i & ~rspur_i;
    end
endmodule

// File: rtl/pat_counter.sv
module pat_counter
    import pat_pkg::*;
#(
    parameter int unsigned MAX_OUTSTANDING = 4,
    parameter int unsigned CNT_W = $clog2(MAX_OUTSTANDING + 1)
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  hs_evt_t            evt_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [NUM_ERR-1:0] viol_o
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_OUTSTANDING);

    logic [CNT_W-1:0] cnt_q;
    logic             orphan;
    logic             over;
    cnt_act_e         act;

    always_comb begin
        orphan = evt_i.retire && (cnt_q == '0);
        over   = evt_i.accept && !evt_i.retire && (cnt_q == CAP);
        act    = pick_action(evt_i.accept && !over, evt_i.retire && !orphan);
        viol_o = '0;
        viol_o[ERR_ORPHAN] = orphan;
        viol_o[ERR_OVER]   = over;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                ACT_INC: cnt_q <= cnt_q + CNT_W'(1);
                ACT_DEC: cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pat_err_pulse.sv
module pat_err_pulse
    import pat_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic [NUM_ERR-1:0] viol_i,
    output logic [NUM_ERR-1:0] err_o
);
    for (genvar g = 0; g < NUM_ERR; g++) begin : g_flag
        always_ff @(posedge clk_i) begin
            if (rst_i) err_o[g] <= 1'b0;
            else       err_o[g] <= viol_i[g] & en_i;
        end
    end
endmodule

// File: rtl/pending_access_tracker.sv
module pending_access_tracker
    import pat_pkg::*;
#(
    parameter int unsigned MAX_OUTSTANDING = 4
) (
    input  logic                                 clk_i,
    input  logic                                 rst_i,
    input  logic                                 req_i,
    input  logic                                 gnt_i,
    input  logic                                 rvalid_i,
    input  logic                                 rspur_i,
    input  logic                                 chk_en_i,
    output logic [$clog2(MAX_OUTSTANDING+1)-1:0] pending_o,
    output logic                                 idle_o,
    output logic                                 err_orphan_o,
    output logic                                 err_overlimit_o
);
    localparam int unsigned CNT_W = $clog2(MAX_OUTSTANDING + 1);

    hs_evt_t            evt;
    logic [NUM_ERR-1:0] viol;
    logic [NUM_ERR-1:0] err;

    pat_hs_decode u_decode (
        .req_i    (req_i),
        .gnt_i    (gnt_i),
        .rvalid_i (rvalid_i),
        .rspur_i  (rspur_i),
        .evt_o    (evt)
    );

    pat_counter #(
        .MAX_OUTSTANDING (MAX_OUTSTANDING),
        .CNT_W           (CNT_W)
    ) u_counter (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .evt_i  (evt),
        .cnt_o  (pending_o),
        .viol_o (viol)
    );

    pat_err_pulse u_err (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (chk_en_i),
        .viol_i (viol),
        .err_o  (err)
    );

    assign idle_o          = (pending_o == '0);
    assign err_orphan_o    = err[ERR_ORPHAN];
    assign err_overlimit_o = err[ERR_OVER];
endmodule

// File: rtl/pat_checker.sv
module pat_checker #(
    parameter int unsigned MAX_OUTSTANDING = 4,
    parameter int unsigned CNT_W = $clog2(MAX_OUTSTANDING + 1)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             req_i,
    input logic             gnt_i,
    input logic             rvalid_i,
    input logic             rspur_i,
    input logic             chk_en_i,
    input logic [CNT_W-1:0] pending_o,
    input logic             idle_o,
    input logic             err_orphan_o,
    input logic             err_overlimit_o
);
    logic acc;
    logic ret;
    assign acc = req_i && gnt_i;
    assign ret = rvalid_i && !rspur_i;

    AST_NO_GRANT_NO_MOVE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!acc && !rvalid_i) |=> $stable(pending_o)); // R1
    AST_ACCEPT_INC: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc && !ret && pending_o < CNT_W'(MAX_OUTSTANDING))
        |=> pending_o == $past(pending_o) + CNT_W'(1)); // R2
    AST_SPUR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!acc && rvalid_i && rspur_i) |=> $stable(pending_o)); // R3
    AST_NET_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc && ret && pending_o != '0) |=> $stable(pending_o)); // R4
    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        idle_o |-> pending_o == '0); // R5
    AST_ORPHAN_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (ret && pending_o == '0 && chk_en_i) |=> err_orphan_o); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        pending_o <= CNT_W'(MAX_OUTSTANDING)); // R7
    AST_MASKED: assert property (@(posedge clk_i) disable iff (rst_i)
        !chk_en_i |=> (!err_orphan_o && !err_overlimit_o)); // R8
endmodule

bind pending_access_tracker pat_checker #(
    .MAX_OUTSTANDING (MAX_OUTSTANDING),
    .CNT_W           (CNT_W)
) chk_i (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .req_i           (req_i),
    .gnt_i           (gnt_i),
    .rvalid_i        (rvalid_i),
    .rspur_i         (rspur_i),
    .chk_en_i        (chk_en_i),
    .pending_o       (pending_o),
    .idle_o          (idle_o),
    .err_orphan_o    (err_orphan_o),
    .err_overlimit_o (err_overlimit_o)
);

// File: tb/pending_access_tracker_tb_top.sv
`timescale 1ns/1ps
module pending_access_tracker_tb_top;
    localparam int MAXO = 4;
    localparam int CW   = $clog2(MAXO + 1);

    logic clk = 1'b0;
    logic rst, req, gnt, rvalid, rspur, chk_en;
    logic [CW-1:0] pending;
    logic idle, err_orph, err_over;

    int n_checks = 0;
    int n_fail   = 0;
    int m_cnt    = 0;
    bit m_eorph  = 0;
    bit m_eover  = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    pending_access_tracker #(.MAX_OUTSTANDING(MAXO)) dut_i (
        .clk_i           (clk),
        .rst_i           (rst),
        .req_i           (req),
        .gnt_i           (gnt),
        .rvalid_i        (rvalid),
        .rspur_i         (rspur),
        .chk_en_i        (chk_en),
        .pending_o       (pending),
        .idle_o          (idle),
        .err_orphan_o    (err_orph),
        .err_overlimit_o (err_over)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "pending", int'(pending), m_cnt);
        check("R5", "idle", int'(idle), int'(m_cnt == 0));
        check(tag, "err_orphan", int'(err_orph), int'(m_eorph));
        check(tag, "err_overlimit", int'(err_over), int'(m_eover));
    endtask

    // One cycle: drive after the falling edge, update the model at the rising edge,
    // compare at the next falling edge.
    task automatic step(input bit r, input bit g, input bit v, input bit s, input bit e,
                        input bit rs, input string tag);
        bit acc, ret, orph, over;
        rst = rs; req = r; gnt = g; rvalid = v; rspur = s; chk_en = e;
        @(posedge clk);
        acc  = r && g;
        ret  = v && !s;
        orph = ret && (m_cnt == 0);
        over = acc && !ret && (m_cnt == MAXO);
        if (rs) begin
            m_cnt = 0; m_eorph = 0; m_eover = 0;
        end else begin
            if (acc && !over) m_cnt++;
            if (ret && !orph) m_cnt--;
            m_eorph = orph && e;
            m_eover = over && e;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(20000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        rst = 1; req = 0; gnt = 0; rvalid = 0; rspur = 0; chk_en = 1;
        @(negedge clk);
        step(0, 0, 0, 0, 1, 1, "R9");
        step(1, 0, 0, 0, 1, 0, "R1");  // request alone
        step(0, 1, 0, 0, 1, 0, "R1");  // grant alone
        for (int i = 0; i < MAXO; i++) step(1, 1, 0, 0, 1, 0, "R2");
        step(1, 1, 0, 0, 1, 0, "R7");  // beyond ceiling
        step(0, 0, 0, 0, 1, 0, "R10"); // pulse falls
        step(1, 1, 1, 0, 1, 0, "R4");  // coincident at ceiling
        step(1, 1, 1, 0, 1, 0, "R4");
        step(0, 0, 1, 1, 1, 0, "R3");  // spurious ignored
        for (int i = 0; i < MAXO; i++) step(0, 0, 1, 0, 1, 0, "R3");
        step(0, 0, 1, 0, 1, 0, "R6");  // orphan
        step(0, 0, 0, 0, 1, 0, "R10");
        step(1, 1, 1, 0, 1, 0, "R6");  // orphan with acceptance
        step(0, 0, 1, 0, 1, 0, "R3");
        step(0, 0, 1, 0, 0, 0, "R8");  // orphan masked
        step(0, 0, 1, 1, 1, 0, "R3");  // spurious at zero
        for (int i = 0; i < MAXO + 1; i++) step(1, 1, 0, 0, 0, 0, "R8");
        step(1, 1, 1, 0, 1, 0, "R4");
        step(0, 0, 0, 0, 1, 1, "R9");  // reset while busy
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[1] | lfsr[5], lfsr[2], lfsr[3] & lfsr[4],
                 lfsr[6] | lfsr[7], 1'b0, "R4");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule